// File: doc/BRIEF.md
# DMA Tag-Group Completion Monitor

This block keeps a count of outstanding DMA commands for each of 32 tag groups. A command enqueue on a tag raises that group's count, and a command completion lowers it. A group whose count is zero is idle. Software selects the groups it cares about with a 32-bit mask, then asks for a status update in one of three modes. The answer is a 32-bit word that has a one for every selected group that is idle.

The status answer leaves the block on a valid/ready stream. In the immediate mode the word is offered at once, even when it is zero. In the two conditional modes the word is held back until the chosen condition holds. The reader is stalled for that time because `stat_valid` stays low. When a word is offered, `stat_valid` stays high and `stat_data` stays stable until the reader accepts it with `stat_ready`. A transfer on `stat_valid && stat_ready` ends the query.

The enqueue, completion, mask and request pins are plain strobes with no back-pressure. Writing a new mask or a new request while a query is waiting or offered abandons the old query. Its word is never delivered, and evaluation starts again with the new settings.

Top module: `tagmon_top`

## Requirements
- R1: After reset every group count is zero, the mask is zero, the mode is immediate and `stat_valid` is low.
- R2: `enq_valid` adds one to the count of group `enq_tag`, and `done_valid` subtracts one from the count of group `done_tag`. A group reads as busy while its count is above zero.
- R3: An enqueue and a completion on the same group in the same cycle leave its count unchanged. On different groups, both take effect.
- R4: Each group holds up to 16 outstanding commands. An enqueue on a group already at 16 has no effect, and a completion on a group at zero has no effect.
- R5: Mask bit i selects tag group i. Bit i of the status word is mask bit i ANDed with "group i idle", and bits outside the mask are zero.
- R6: Mode code 2'b00 (immediate) offers the status word on the second rising edge after the request strobe, even when the word is zero. Code 2'b11 behaves the same way.
- R7: Mode code 2'b01 (wait-any) keeps `stat_valid` low until at least one masked group is idle. The word is then offered one edge after the condition first holds.
- R8: Mode code 2'b10 (wait-all) keeps `stat_valid` low until every masked group is idle. The word is then offered one edge after the condition first holds. With an empty mask, the query completes at once with a zero word.
- R9: While `stat_valid` is high and `stat_ready` is low, `stat_data` and `stat_valid` hold, even if counts change. A transfer drops `stat_valid` on the next edge.
- R10: An `upd_wr` or `mask_wr` strobe while a query is waiting or offered cancels that query. A new evaluation starts with the current mask and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | A command was enqueued this cycle |
| enq_tag | input | 5 | Tag group of the enqueued command |
| done_valid | input | 1 | A command completed this cycle |
| done_tag | input | 5 | Tag group of the completed command |
| mask_wr | input | 1 | Load `mask_data` into the tag mask |
| mask_data | input | 32 | New tag mask, bit i for group i |
| upd_wr | input | 1 | Start a status query |
| upd_mode | input | 2 | Query mode: 00 immediate, 01 wait-any, 10 wait-all |
| stat_valid | output | 1 | Status word is offered |
| stat_ready | input | 1 | Reader accepts the status word |
| stat_data | output | 32 | Status word, one bit per masked idle group |

## Verification
The bench sweeps every tag with several command counts and checks immediate status under shifting masks. A design that decoded the tag wrongly, or leaked unmasked bits, would return the wrong word.

It pushes one group past 16 outstanding commands and completes it past zero. A counter that wrapped instead of holding would then read idle one completion too early, or idle after a fresh enqueue. Same-cycle enqueue and completion pairs expose a design that gives either event priority.

The conditional modes are held on a three-tag mask while groups drain one by one. A wait-any design that fired early, or a wait-all design that fired after the first idle group, would offer the word at the wrong edge. The bench also stalls the reader while counts change, and rewrites the mask during a pending query. A design that let `stat_data` drift, or that kept serving a cancelled query, would be caught.

// File: rtl/tagmon_pkg.sv
package tagmon_pkg;
  typedef enum logic [1:0] {
    UPD_IMM = 2'b00,
    UPD_ANY = 2'b01,
    UPD_ALL = 2'b10,
    UPD_RSV = 2'b11
  } upd_mode_e;

  typedef enum logic [1:0] {
    Q_IDLE,
    Q_PEND,
    Q_SHOW
  } qstate_e;
endpackage

// File: rtl/tagmon_counter.sv
module tagmon_counter #(
  parameter int MAX_OUT = 16,
  localparam int CNT_W = $clog2(MAX_OUT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic idle
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (inc && !dec && cnt != CNT_W'(MAX_OUT)) begin
      cnt <= cnt + 1'b1;
    end else if (dec && !inc && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign idle = (cnt == '0);

  // R4
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_OUT));

  // R3
  pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> $stable(cnt));
endmodule

// File: rtl/tagmon_eval.sv
module tagmon_eval
  import tagmon_pkg::*;
#(
  parameter int NUM_TAGS = 32
) (
  input  logic [NUM_TAGS-1:0] idle_vec,
  input  logic [NUM_TAGS-1:0] mask,
  input  upd_mode_e           mode,
  output logic [NUM_TAGS-1:0] status,
  output logic                hit
);
  always_comb begin
    status = mask & idle_vec;
    unique case (mode)
      UPD_ANY: hit = |status;
      UPD_ALL: hit = (status == mask);
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/tagmon_query.sv
module tagmon_query
  import tagmon_pkg::*;
#(
  parameter int NUM_TAGS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mask_wr,
  input  logic [NUM_TAGS-1:0] mask_data,
  input  logic                upd_wr,
  input  upd_mode_e           upd_mode,
  input  logic                hit,
  input  logic [NUM_TAGS-1:0] status,
  output logic [NUM_TAGS-1:0] mask_q,
  output upd_mode_e           mode_q,
  input  logic                stat_ready,
  output logic                stat_valid,
  output logic [NUM_TAGS-1:0] stat_data
);
  qstate_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= Q_IDLE;
      mode_q    <= UPD_IMM;
      mask_q    <= '0;
      stat_data <= '0;
    end else begin
      if (mask_wr) mask_q <= mask_data;
      if (upd_wr)  mode_q <= upd_mode;
      if (upd_wr || (mask_wr && state != Q_IDLE)) begin
        state <= Q_PEND;
      end else begin
        unique case (state)
          Q_PEND: if (hit) begin
            stat_data <= status;
            state     <= Q_SHOW;
          end
          Q_SHOW: if (stat_ready) state <= Q_IDLE;
          default: state <= Q_IDLE;
        endcase
      end
    end
  end

  assign stat_valid = (state == Q_SHOW);

  // R9
  show_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && !stat_ready && !upd_wr && !mask_wr)
      |=> (stat_valid && $stable(stat_data)));

  // R5
  in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_valid |-> ((stat_data & ~mask_q) == '0));

  // R8
  all_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && mode_q == UPD_ALL) |-> (stat_data == mask_q));

  // R7
  any_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && mode_q == UPD_ANY) |-> (stat_data != '0));

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_wr |=> !stat_valid);
endmodule

// File: rtl/tagmon_top.sv
module tagmon_top
  import tagmon_pkg::*;
#(
  parameter int NUM_TAGS = 32,
  parameter int MAX_OUT  = 16,
  localparam int TAG_W = $clog2(NUM_TAGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enq_valid,
  input  logic [TAG_W-1:0]    enq_tag,
  input  logic                done_valid,
  input  logic [TAG_W-1:0]    done_tag,
  input  logic                mask_wr,
  input  logic [NUM_TAGS-1:0] mask_data,
  input  logic                upd_wr,
  input  logic [1:0]          upd_mode,
  output logic                stat_valid,
  input  logic                stat_ready,
  output logic [NUM_TAGS-1:0] stat_data
);
  logic [NUM_TAGS-1:0] idle_vec;
  logic [NUM_TAGS-1:0] mask_q;
  logic [NUM_TAGS-1:0] status;
  upd_mode_e           mode_q;
  logic                hit;

  for (genvar g = 0; g < NUM_TAGS; g++) begin : g_grp
    tagmon_counter #(.MAX_OUT(MAX_OUT)) u_cnt (
      .clk  (clk),
      .rst_n(rst_n),
      .inc  (enq_valid  && enq_tag  == TAG_W'(g)),
      .dec  (done_valid && done_tag == TAG_W'(g)),
      .idle (idle_vec[g])
    );
  end

  tagmon_eval #(.NUM_TAGS(NUM_TAGS)) u_eval (
    .idle_vec(idle_vec),
    .mask    (mask_q),
    .mode    (mode_q),
    .status  (status),
    .hit     (hit)
  );

  tagmon_query #(.NUM_TAGS(NUM_TAGS)) u_query (
    .clk       (clk),
    .rst_n     (rst_n),
    .mask_wr   (mask_wr),
    .mask_data (mask_data),
    .upd_wr    (upd_wr),
    .upd_mode  (upd_mode_e'(upd_mode)),
    .hit       (hit),
    .status    (status),
    .mask_q    (mask_q),
    .mode_q    (mode_q),
    .stat_ready(stat_ready),
    .stat_valid(stat_valid),
    .stat_data (stat_data)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !stat_valid);
endmodule

// File: tb/tagmon_top_test.sv
module tagmon_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enq_valid = 1'b0, done_valid = 1'b0;
  logic [4:0]  enq_tag = '0, done_tag = '0;
  logic        mask_wr = 1'b0, upd_wr = 1'b0, stat_ready = 1'b0;
  logic [31:0] mask_data = '0;
  logic [1:0]  upd_mode = '0;
  logic        stat_valid;
  logic [31:0] stat_data;

  int checks = 0, errors = 0;
  int cm[32];
  logic [31:0] held;

  always #10 clk = ~clk;

  tagmon_top uut (.*);

  function automatic logic [31:0] idle_m();
    logic [31:0] v;
    for (int i = 0; i < 32; i++) v[i] = (cm[i] == 0);
    return v;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one cycle of enqueue/completion with the model updated per R2-R4
  task automatic ev(input logic ev_e, input int te, input logic ev_d, input int td);
    enq_valid = ev_e; enq_tag = 5'(te);
    done_valid = ev_d; done_tag = 5'(td);
    step();
    enq_valid = 0; done_valid = 0;
    if (ev_e && ev_d && te == td) begin
    end else begin
      if (ev_e && cm[te] < 16) cm[te]++;
      if (ev_d && cm[td] > 0) cm[td]--;
    end
  endtask

  task automatic request(input logic [1:0] mode, input logic [31:0] m);
    mask_wr = 1; mask_data = m; upd_wr = 1; upd_mode = mode;
    step();
    mask_wr = 0; upd_wr = 0;
  endtask

  task automatic take();
    stat_ready = 1; step(); stat_ready = 0;
  endtask

  // immediate query, checked on the second edge after the strobe (R6)
  task automatic imm_check(input string req, input logic [31:0] m);
    request(2'b00, m);
    step();
    chk({req, " valid"}, 32'(stat_valid), 32'd1);
    chk(req, stat_data, m & idle_m());
    take();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) cm[i] = 0;
    repeat (3) step();
    chk("R1 valid in reset", 32'(stat_valid), 32'd0);
    rst_n = 1; step();
    chk("R1 valid after reset", 32'(stat_valid), 32'd0);
    imm_check("R1 all idle", 32'hFFFF_FFFF);
    imm_check("R6 empty mask zero word", 32'h0);

    // R2 R5 sweep: load every group, then drain with varying masks
    for (int t = 0; t < 32; t++)
      for (int k = 0; k <= t % 4; k++) ev(1, t, 0, 0);
    imm_check("R2 all busy", 32'hFFFF_FFFF);
    for (int t = 0; t < 32; t++) begin
      ev(0, 0, 1, t);
      imm_check("R5 sweep", 32'hFFFF_FFFF ^ (32'h9E37_79B1 * 32'(t + 1)));
    end
    for (int t = 0; t < 32; t++)
      while (cm[t] > 0) ev(0, 0, 1, t);
    imm_check("R2 drained", 32'hFFFF_FFFF);
    request(2'b11, 32'h0000_00F0);
    step();
    chk("R6 code 11 valid", 32'(stat_valid), 32'd1);
    chk("R6 code 11 data", stat_data, 32'h0000_00F0);
    take();

    // R4 saturation and underflow
    for (int k = 0; k < 18; k++) ev(1, 3, 0, 0);
    for (int k = 0; k < 15; k++) ev(0, 0, 1, 3);
    imm_check("R4 one left after cap", 32'h0000_0008);
    ev(0, 0, 1, 3);
    imm_check("R4 idle at 16 completions", 32'h0000_0008);
    ev(0, 0, 1, 3);
    ev(1, 3, 0, 0);
    imm_check("R4 no underflow", 32'h0000_0008);
    ev(0, 0, 1, 3);

    // R3 simultaneous events
    ev(1, 7, 0, 0); ev(1, 7, 0, 0);
    for (int k = 0; k < 5; k++) ev(1, 7, 1, 7);
    ev(0, 0, 1, 7);
    imm_check("R3 same group pair", 32'h0000_0080);
    ev(1, 8, 1, 7);
    imm_check("R3 different groups", 32'h0000_0180);
    ev(0, 0, 1, 8);

    // R7 wait-any on tags 5, 14, 31
    ev(1, 5, 0, 0); ev(1, 14, 0, 0); ev(1, 31, 0, 0);
    request(2'b01, 32'h8000_4020);
    repeat (4) step();
    chk("R7 stalls while all busy", 32'(stat_valid), 32'd0);
    ev(0, 0, 1, 14);
    chk("R7 not yet one edge after", 32'(stat_valid), 32'd0);
    step();
    chk("R7 valid", 32'(stat_valid), 32'd1);
    chk("R7 data", stat_data, 32'h0000_4000);
    take();
    chk("R9 drop after transfer", 32'(stat_valid), 32'd0);

    // R8 wait-all
    request(2'b10, 32'h8000_4020);
    ev(0, 0, 1, 5);
    repeat (3) step();
    chk("R8 stalls with one busy", 32'(stat_valid), 32'd0);
    ev(0, 0, 1, 31);
    step();
    chk("R8 valid", 32'(stat_valid), 32'd1);
    chk("R8 data", stat_data, 32'h8000_4020);

    // R9 back-pressure with counts moving
    held = stat_data;
    ev(1, 14, 0, 0);
    ev(1, 5, 0, 0);
    step();
    chk("R9 held valid", 32'(stat_valid), 32'd1);
    chk("R9 held data", stat_data, held);
    take();
    chk("R9 drop", 32'(stat_valid), 32'd0);
    request(2'b10, 32'h0);
    step();
    chk("R8 empty mask valid", 32'(stat_valid), 32'd1);
    chk("R8 empty mask data", stat_data, 32'h0);
    take();

    // R10 cancel by mask write and by new request
    request(2'b01, 32'h0000_4000);
    step(); step();
    chk("R10 pending on busy", 32'(stat_valid), 32'd0);
    mask_wr = 1; mask_data = 32'h0000_0400; step(); mask_wr = 0;
    step();
    chk("R10 restarted valid", 32'(stat_valid), 32'd1);
    chk("R10 restarted data", stat_data, 32'h0000_0400);
    request(2'b00, 32'h0000_4020);
    chk("R10 cancel drops valid", 32'(stat_valid), 32'd0);
    step();
    chk("R10 new query data", stat_data, 32'h0000_4020 & idle_m());
    take();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule